// File: doc/BRIEF.md
# Self-Checking Two-Rail Word Comparator

This block decides whether two words of W bits are equal, for example the bus values of two processors running in lockstep. Each bit position is encoded as a two-rail pair made of the bit from the first word and the inverse of the matching bit from the second word. A balanced tree of two-rail checker cells then reduces these pairs to a single output pair.

The output pair is complementary (01 or 10) when the words agree. It is 00 or 11 when they disagree. Because of this coding, any single stuck-at fault inside the tree gives a non-complementary pair for some pair of matching words. Normal traffic with equal words is therefore enough to expose faults in the comparator itself.

An exclusive-NOR stage turns the output pair into one error flag. The single-rail path after the tree is not self-checking, so a test input is provided. The test input inverts bit 0 of the first word before the comparison, which makes the flag rise for words that are otherwise equal. When W is not a power of two, the tree is filled up with constant matching pairs.

Top module: `tworail_eq_cmp`

## Requirements
- R1: When `inject` is 0 and `word_a` equals `word_b`, `rail` is 01 or 10 and `mismatch` is 0.
- R2: When the compared words differ in any way, `rail` is 00 or 11.
- R3: When `inject` is 1, bit 0 of `word_a` is inverted before the comparison. Equal input words then raise `mismatch`. Words that differ only in bit 0 give `mismatch` = 0 and a complementary `rail`.
- R4: `mismatch` is 1 exactly when the compared words (after R3's inversion) differ, and 0 otherwise.
- R5: Every bit position from 0 to W-1 takes part in the comparison. Flipping any single bit of `word_b` alone sets `mismatch` to 1. This holds for the default W = 12, which is not a power of two.
- R6: A difference in an even number of bit positions is detected (`mismatch` = 1), just as an odd number is.
- R7: The outputs are purely combinational. They follow the inputs with no clock and hold no state. With all inputs at 0, `rail` is complementary and `mismatch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_a | input | W | First word compared |
| word_b | input | W | Second word compared |
| inject | input | 1 | Test control: inverts bit 0 of word_a before the comparison |
| rail | output | 2 | Two-rail result; complementary means the words match |
| mismatch | output | 1 | Single-rail error flag, 1 when the words differ |

## Verification
On every evaluation, the embedded assertions check three things:
- Matching words give a complementary pair and a clear flag.
- Differing words give a non-complementary pair.
- The flag agrees with the compared words, including the inversion of bit 0 under test.

Some behaviours can only be shown by the bench's scenarios:
- Every individual bit position, including those next to the padded part of the tree, reaches the root.
- Even-count differences are not cancelled out.
- Words that differ only in bit 0 are made to match by `inject`.

// File: rtl/tworail_eq_cmp.sv
module tworail_eq_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic         inject,
  output logic [1:0]   rail,
  output logic         mismatch
);
  localparam int LVL = $clog2(W);
  localparam int P   = 1 << LVL;

  logic [W-1:0] a_cmp;
  assign a_cmp = word_a ^ {{(W-1){1'b0}}, inject};

  genvar l, j;
  for (l = 0; l <= LVL; l++) begin : g_lvl
    localparam int M = P >> l;
    logic [M-1:0] z0, z1;
    if (l == 0) begin : g_leaf
      for (j = 0; j < M; j++) begin : g_bit
        if (j < W) begin : g_real
          assign z0[j] = a_cmp[j];
          assign z1[j] = ~word_b[j];
        end else begin : g_pad
          assign z0[j] = 1'b0;
          assign z1[j] = 1'b1;
        end
      end
    end else begin : g_node
      for (j = 0; j < M; j++) begin : g_cell
        assign z0[j] = (g_lvl[l-1].z0[2*j] & g_lvl[l-1].z0[2*j+1])
                     | (g_lvl[l-1].z1[2*j] & g_lvl[l-1].z1[2*j+1]);
        assign z1[j] = (g_lvl[l-1].z0[2*j] & g_lvl[l-1].z1[2*j+1])
                     | (g_lvl[l-1].z1[2*j] & g_lvl[l-1].z0[2*j+1]);
      end
    end
  end

  assign rail     = {g_lvl[LVL].z0[0], g_lvl[LVL].z1[0]};
  assign mismatch = ~(rail[1] ^ rail[0]);

  always_comb begin
    if (!inject && (word_a == word_b))
      assert_match_clean_R1: assert (rail[1] != rail[0] && !mismatch);
    if ((word_a ^ {{(W-1){1'b0}}, inject}) != word_b)
      assert_diff_noncode_R2: assert (rail[1] == rail[0]);
    if (inject && (word_a == word_b))
      assert_inject_flags_R3: assert (mismatch);
    assert_flag_tracks_words_R4: assert (mismatch == ((word_a ^ {{(W-1){1'b0}}, inject}) != word_b));
  end
endmodule

// File: tb/tb_tworail_eq_cmp.sv
module tb_tworail_eq_cmp;
  localparam int W = 12;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] word_a, word_b;
  logic inject;
  logic [1:0] rail;
  logic mismatch;
  int total = 0;
  int bad = 0;
  bit done = 0;

  tworail_eq_cmp #(.W(W)) dut (.word_a(word_a), .word_b(word_b), .inject(inject),
                               .rail(rail), .mismatch(mismatch));

  function automatic logic exp_err(logic [W-1:0] a, logic [W-1:0] b, logic inj);
    return (a ^ {{(W-1){1'b0}}, inj}) != b;
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic inj, input string req);
    logic e;
    word_a = a; word_b = b; inject = inj;
    @(negedge clk);
    e = exp_err(a, b, inj);
    total++;
    if (mismatch !== e) begin
      bad++;
      $display("FAIL %s mismatch a=%h b=%h inj=%b actual=%b expected=%b", req, a, b, inj, mismatch, e);
    end
    total++;
    if ((rail[1] != rail[0]) !== !e) begin
      bad++;
      $display("FAIL %s rail a=%h b=%h inj=%b actual=%b expected_complementary=%b", req, a, b, inj, rail, !e);
    end
  endtask

  initial begin
    logic [W-1:0] r, s;
    word_a = '0; word_b = '0; inject = 1'b0;
    @(negedge clk);
    total++;
    if (rail[1] == rail[0] || mismatch !== 1'b0) begin
      bad++;
      $display("FAIL R7 idle rail=%b mismatch=%b expected complementary and 0", rail, mismatch);
    end
    r = W'($urandom(32'd7351));
    apply('0, '0, 1'b0, "R1");
    apply('1, '1, 1'b0, "R1");
    apply(r, r, 1'b0, "R1");
    apply('0, '1, 1'b0, "R2");
    apply(r, ~r, 1'b0, "R2");
    apply(r, r, 1'b1, "R3");
    apply('0, '0, 1'b1, "R3");
    apply(r, r ^ 12'h001, 1'b1, "R3");
    apply(r, r ^ 12'h003, 1'b1, "R4");
    for (int k = 0; k < W; k++) begin
      s = W'($urandom);
      apply(s, s ^ (W'(1) << k), 1'b0, "R5");
    end
    for (int k = 0; k < W - 1; k++) begin
      s = W'($urandom);
      apply(s, s ^ (W'(3) << k), 1'b0, "R6");
    end
    for (int n = 0; n < 300; n++) begin
      s = W'($urandom);
      r = (n % 2 == 0) ? s : W'($urandom);
      apply(s, r, 1'($urandom), "R4");
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule